// File: doc/BRIEF.md
# Hyperplane-Tree Piecewise-Affine Evaluator

This block computes a piecewise-affine map of a four-component signed input vector. The input space is split into convex regions, and each region has its own affine law. Evaluation runs in two phases. First, a binary decision tree is walked from node 0. Each internal node tests one hyperplane and moves to one of its two children. Each leaf names a region. Second, that region's affine law is evaluated. Both phases share one signed multiplier that accumulates at double width. A typical use is as the control-law core of a fast sampled regulator: a state estimate goes in once per sample period, and the actuator command comes out.

The tree nodes and the region laws are held in on-block RAMs. They are filled through a narrow word-write port while the block is idle. Once filled, a single-cycle `start` pulse latches the four inputs. `busy` then stays high until `valid` pulses with the saturated result.

Top module: `pwa_tree_eval`

## Requirements
- R1: After reset, `busy` and `valid` are 0 and `result` is 0.
- R2: A `start` pulse seen while idle raises `busy` at the next edge. `busy` stays high until the cycle in which `valid` is high. In that cycle `busy` is low. `valid` lasts exactly one cycle.
- R3: The walk begins at node 0. At an internal node it forms s = h0·y0 + h1·y1 + h2·y2 + h3·y3 − k·2^FRAC. It goes to the left child when s ≤ 0 and to the right child otherwise. A tie at s = 0 goes left.
- R4: A node's link word has the leaf flag at bit 2·NAW, the left link at bits [2·NAW−1:NAW] and the right link at bits [NAW−1:0]. With NAW = 6 these are bit 12, bits [11:6] and bits [5:0]. At a leaf, the left-link field is the region index.
- R5: For region r, the pre-saturation result is floor((F0·y0 + F1·y1 + F2·y2 + F3·y3 + G·2^FRAC) / 2^FRAC), using an arithmetic shift. FRAC defaults to 8.
- R6: `result` saturates to the signed OW-bit range. With OW = 16 that range is −32768 to 32767.
- R7: If the leaf lies below d internal nodes, `valid` rises 6·d + 6 clock edges after the edge that sampled `start`.
- R8: A `start` pulse that arrives while `busy` is high is ignored. So are input changes during `busy`. Exactly one `valid` is produced, and it carries the values latched at the accepted start.
- R9: `result` changes only in a cycle where `valid` is high, and it holds between results.
- R10: A write with `wr_space` = 0 targets tree node `wr_index`. Fields 0 to 3 are the hyperplane coefficients, field 4 is the offset k and field 5 is the link word. A write with `wr_space` = 1 targets region `wr_index`. Fields 0 to 3 are F and field 4 is G. Rewritten contents take effect at the next evaluation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Table write strobe |
| wr_space | input | 1 | 0 selects tree RAM, 1 selects region-law RAM |
| wr_index | input | NAW | Node or region index |
| wr_field | input | 3 | Field within the entry |
| wr_data | input | CW | Signed coefficient or link word |
| start | input | 1 | Begin an evaluation (ignored while busy) |
| y0 | input | DW | Input component 0, signed |
| y1 | input | DW | Input component 1, signed |
| y2 | input | DW | Input component 2, signed |
| y3 | input | DW | Input component 3, signed |
| busy | output | 1 | Evaluation in progress |
| valid | output | 1 | One-cycle result strobe |
| result | output | OW | Saturated signed result |

## Verification
A wrong branch decision at any node shows up at the ports in two ways. The result matches a different region's law, and the latency moves by a multiple of six cycles because the depth changed. Each evaluation is therefore scored on both its value and its cycle count. A sign or tie error in the node test appears as soon as an input sits exactly on a hyperplane. A stuck accumulator or a bad saturation shows in the first result that leaves the output range. A control state that fails to return to idle shows as `busy` never falling, or as a second, unrequested `valid`.

// File: rtl/pwa_tree_eval.sv
module pwa_tree_eval #(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int OW   = 16,
  parameter int NAW  = 6,
  parameter int FRAC = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 wr_space,
  input  logic [NAW-1:0]       wr_index,
  input  logic [2:0]           wr_field,
  input  logic [CW-1:0]        wr_data,
  input  logic                 start,
  input  logic signed [DW-1:0] y0,
  input  logic signed [DW-1:0] y1,
  input  logic signed [DW-1:0] y2,
  input  logic signed [DW-1:0] y3,
  output logic                 busy,
  output logic                 valid,
  output logic [OW-1:0]        result
);
  localparam int NN = 1 << NAW;
  localparam int PW = DW + CW;
  localparam int AW = PW + FRAC + 3;
  localparam int LW = 2 * NAW + 1;
  localparam logic signed [AW-1:0] OMAX = {{(AW-OW+1){1'b0}}, {(OW-1){1'b1}}};
  localparam logic signed [AW-1:0] OMIN = {{(AW-OW+1){1'b1}}, {(OW-1){1'b0}}};

  typedef enum logic [2:0] {S_IDLE, S_VISIT, S_TEST, S_DECIDE, S_LAW, S_DONE} st_t;

  logic signed [CW-1:0] hp [NN][4];
  logic signed [CW-1:0] hoff [NN];
  logic [LW-1:0]        link [NN];
  logic signed [CW-1:0] fc [NN][4];
  logic signed [CW-1:0] gc [NN];

  st_t                  st;
  logic [NAW-1:0]       node, rgn;
  logic [1:0]           j;
  logic signed [AW-1:0] acc;
  logic signed [DW-1:0] ys [4];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      if (!wr_space) begin
        if (wr_field < 3'd4)       hp[wr_index][wr_field[1:0]] <= wr_data;
        else if (wr_field == 3'd4) hoff[wr_index] <= wr_data;
        else if (wr_field == 3'd5) link[wr_index] <= wr_data[LW-1:0];
      end else begin
        if (wr_field < 3'd4)       fc[wr_index][wr_field[1:0]] <= wr_data;
        else if (wr_field == 3'd4) gc[wr_index] <= wr_data;
      end
    end
  end

  logic [LW-1:0]        cur_link;
  logic                 is_leaf;
  logic [NAW-1:0]       lft, rgt;
  logic signed [CW-1:0] coef;
  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] prod_x, off_x, g_x, shifted;
  logic [OW-1:0]        sat_val;

  assign cur_link = link[node];
  assign is_leaf  = cur_link[LW-1];
  assign lft      = cur_link[LW-2:NAW];
  assign rgt      = cur_link[NAW-1:0];
  assign coef     = (st == S_LAW) ? fc[rgn][j] : hp[node][j];
  assign prod     = coef * ys[j];
  assign prod_x   = {{(AW-PW){prod[PW-1]}}, prod};
  assign off_x    = {{(AW-CW-FRAC){hoff[node][CW-1]}}, hoff[node], {FRAC{1'b0}}};
  assign g_x      = {{(AW-CW-FRAC){gc[lft][CW-1]}}, gc[lft], {FRAC{1'b0}}};
  assign shifted  = acc >>> FRAC;
  assign sat_val  = (shifted > OMAX) ? OMAX[OW-1:0] :
                    (shifted < OMIN) ? OMIN[OW-1:0] : shifted[OW-1:0];
  assign busy     = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      node   <= '0;
      rgn    <= '0;
      j      <= '0;
      acc    <= '0;
      valid  <= 1'b0;
      result <= '0;
      for (int i = 0; i < 4; i++) ys[i] <= '0;
    end else begin
      valid <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          ys[0] <= y0;
          ys[1] <= y1;
          ys[2] <= y2;
          ys[3] <= y3;
          node  <= '0;
          st    <= S_VISIT;
        end
        S_VISIT: begin
          j <= '0;
          if (is_leaf) begin
            rgn <= lft;
            acc <= g_x;
            st  <= S_LAW;
          end else begin
            acc <= -off_x;
            st  <= S_TEST;
          end
        end
        S_TEST: begin
          acc <= acc + prod_x;
          j   <= j + 2'd1;
          if (j == 2'd3) st <= S_DECIDE;
        end
        S_DECIDE: begin
          node <= (acc[AW-1] || acc == '0) ? lft : rgt;
          st   <= S_VISIT;
        end
        S_LAW: begin
          acc <= acc + prod_x;
          j   <= j + 2'd1;
          if (j == 2'd3) st <= S_DONE;
        end
        S_DONE: begin
          result <= sat_val;
          valid  <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pwa_tree_eval_chk.sv
module pwa_tree_eval_chk #(
  parameter int OW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          valid,
  input logic [OW-1:0] result
);
  AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R2
  AST_VALID_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (!busy && $past(busy))); // R2
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid); // R2
  AST_BUSY_FALLS_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> valid); // R2
  AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> (busy || valid)); // R8
  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> $stable(result)); // R9
endmodule

bind pwa_tree_eval pwa_tree_eval_chk #(.OW(OW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .valid(valid), .result(result)
);

// File: tb/sim_pwa_tree_eval.sv
module sim_pwa_tree_eval;
  localparam int DW = 16, CW = 16, OW = 16, NAW = 6, FRAC = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, wr_space = 1'b0;
  logic [NAW-1:0] wr_index = '0;
  logic [2:0] wr_field = '0;
  logic [CW-1:0] wr_data = '0;
  logic start = 1'b0;
  logic signed [DW-1:0] y0 = '0, y1 = '0, y2 = '0, y3 = '0;
  logic busy, valid;
  logic [OW-1:0] result;

  pwa_tree_eval #(.DW(DW), .CW(CW), .OW(OW), .NAW(NAW), .FRAC(FRAC)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_space(wr_space), .wr_index(wr_index),
    .wr_field(wr_field), .wr_data(wr_data), .start(start), .y0(y0), .y1(y1), .y2(y2),
    .y3(y3), .busy(busy), .valid(valid), .result(result));

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0, n_push = 0, n_valid = 0;

  typedef struct { int val; int lat; int stamp; string req; } item_t;
  item_t sb[$];

  int mh [64][4], mk [64], mleaf [64], ml [64], mr [64], mf [64][4], mg [64];

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input bit sp, input int idx, input int fld, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_space = sp; wr_index = idx[NAW-1:0];
    wr_field = fld[2:0]; wr_data = data[CW-1:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_node(input int idx, input int h0, input int h1, input int h2,
                          input int h3, input int k, input int l, input int r);
    mh[idx] = '{h0, h1, h2, h3}; mk[idx] = k; mleaf[idx] = 0; ml[idx] = l; mr[idx] = r;
    wr(0, idx, 0, h0); wr(0, idx, 1, h1); wr(0, idx, 2, h2); wr(0, idx, 3, h3);
    wr(0, idx, 4, k);
    wr(0, idx, 5, (l << NAW) | r);
  endtask

  task automatic set_leaf(input int idx, input int region);
    mleaf[idx] = 1; ml[idx] = region; mr[idx] = 0;
    wr(0, idx, 5, (1 << (2 * NAW)) | (region << NAW));
  endtask

  task automatic set_law(input int r, input int f0, input int f1, input int f2,
                         input int f3, input int g);
    mf[r] = '{f0, f1, f2, f3}; mg[r] = g;
    wr(1, r, 0, f0); wr(1, r, 1, f1); wr(1, r, 2, f2); wr(1, r, 3, f3); wr(1, r, 4, g);
  endtask

  function automatic void model(input int v0, input int v1, input int v2, input int v3,
                                output int val, output int depth);
    longint yv [4];
    longint s, q;
    int n;
    yv = '{v0, v1, v2, v3};
    n = 0; depth = 0;
    while (mleaf[n] == 0) begin
      s = -(longint'(mk[n]) * (1 << FRAC));
      for (int i = 0; i < 4; i++) s += longint'(mh[n][i]) * yv[i];
      n = (s <= 0) ? ml[n] : mr[n];
      depth++;
    end
    s = longint'(mg[ml[n]]) * (1 << FRAC);
    for (int i = 0; i < 4; i++) s += longint'(mf[ml[n]][i]) * yv[i];
    q = s >>> FRAC;
    if (q > 32767) q = 32767;
    if (q < -32768) q = -32768;
    val = int'(q);
  endfunction

  task automatic run(input int v0, input int v1, input int v2, input int v3, input string req);
    item_t it;
    int d;
    @(negedge clk);
    while (busy) @(negedge clk);
    y0 = v0[DW-1:0]; y1 = v1[DW-1:0]; y2 = v2[DW-1:0]; y3 = v3[DW-1:0];
    model(v0, v1, v2, v3, it.val, d);
    it.lat = 6 * d + 6; it.stamp = cyc + 1; it.req = req;
    sb.push_back(it); n_push++;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && valid) begin
      n_valid++;
      if (sb.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R8 unexpected valid actual=%0d expected=none", $signed(result));
      end else begin
        item_t it;
        it = sb.pop_front();
        check(it.req, int'($signed(result)), it.val);
        check({"R7 latency ", it.req}, cyc - it.stamp, it.lat);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [OW-1:0] held;
    repeat (3) @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 valid", valid, 0);
    check("R1 result", result, 0);
    rst_n = 1'b1;

    // R10: fill tables through the write port
    set_node(0, 256, 0, 0, 0, 20, 1, 2);
    set_node(1, 0, 256, -128, 64, 1, 3, 4);
    set_leaf(2, 2);
    set_leaf(3, 0);
    set_leaf(4, 1);
    set_law(0, 256, 0, 0, 0, 5);
    set_law(1, 128, 256, -64, 32, -3);
    set_law(2, 32767, 32767, 0, 0, 0);

    run(5, 0, 0, 0, "R3 left-left walk");
    run(20, 0, 0, 0, "R3 tie at root goes left");
    run(21, 3, 0, 0, "R4 leaf under root");
    run(10, 5, 2, 4, "R5 four-term law");
    run(-3, -1, 0, 0, "R3 negative inputs");
    run(0, 2, 0, 1, "R5 floor of negative");
    run(300, 300, 0, 0, "R6 positive saturation");
    run(21, -1000, 0, 0, "R6 negative saturation");

    // R8: second start and input changes while busy
    @(negedge clk);
    y0 = 16'sd7; y1 = 0; y2 = 0; y3 = 0;
    begin
      item_t it; int d;
      model(7, 0, 0, 0, it.val, d);
      it.lat = 6 * d + 6; it.stamp = cyc + 1; it.req = "R8 start ignored while busy";
      sb.push_back(it); n_push++;
    end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    y0 = 16'sd25; y1 = 16'sd9; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
    repeat (30) @(negedge clk);

    // R9: result holds after inputs move
    held = result;
    y0 = -16'sd100; y2 = 16'sd55;
    repeat (10) @(negedge clk);
    check("R9 result holds", result, held);

    // R10: rewrite a region offset, takes effect next evaluation
    set_law(0, 256, 0, 0, 0, 100);
    run(5, 0, 0, 0, "R10 rewritten offset");

    repeat (20) @(negedge clk);
    check("R8 valid count", n_valid, n_push);
    check("R2 idle at end", busy, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule